// File: doc/BRIEF.md
# ISA Extension Register Write Legalizer

This block holds the architectural register that advertises which instruction-set extensions a hart has turned on. It filters every software write to that register through a fixed chain of legality rules, so that the stored value only ever holds a consistent set of extensions. The current value is always visible on a combinational read port.

A write is taken only when a configuration input allows software to change the register at all. The write data must name the base integer set, and must not name the reduced-register base. Accepted data is trimmed to the extensions the hart supports and to the letters the block understands. Two dependency fixes follow: double precision is dropped without single precision, and compressed is dropped when the next instruction would be misaligned. The two-bit base-width field at the top is locked. When the stored value changes, a one-cycle pulse tells the front end to discard any decoded instructions.

Top module: `isa_ext_legalizer`

## Requirements
- R1: On a synchronous reset (rst_n low at a rising edge) misa_q becomes {MXL_INIT, zeros, hart_ext_mask} and flush_pulse is 0.
- R2: While writable_en is 0 a strobed write leaves misa_q unchanged and raises no flush_pulse.
- R3: A strobed write whose data has both bit 8 (I) and bit 4 (E) clear is dropped entirely.
- R4: A strobed write whose data has bit 4 (E) set is dropped entirely, whatever else it holds.
- R5: An accepted write stores data ANDed with hart_ext_mask and with the letter set A(0), C(2), D(3), E(4), F(5), I(8), M(12), S(18), U(20). Bits 26 up to XLEN-3 always read zero.
- R6: If, after masking, bit 3 (D) is set and bit 5 (F) is clear, bit 3 is stored as 0.
- R7: If bit 2 (C) survives masking while next_pc_aligned is 0, bit 2 is stored as 0.
- R8: The top two bits of misa_q keep their current value on every write, whatever the data holds there.
- R9: flush_pulse is high for exactly the one cycle in which an accepted write's new value first appears on misa_q, and only if that value differs from the previous one.
- R10: Without a strobed, accepted write misa_q holds its value and flush_pulse is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe, one write per cycle it is high |
| wr_data | input | XLEN | Raw write data from software |
| hart_ext_mask | input | 26 | Static set of extensions this hart implements, one bit per letter |
| writable_en | input | 1 | Allows software writes to change the register |
| next_pc_aligned | input | 1 | High when the next instruction address is a multiple of four |
| misa_q | output | XLEN | Current register value |
| flush_pulse | output | 1 | One-cycle pulse when the stored value changes |

## Verification
The assertions take hart_ext_mask as static once reset is released, and they check the D-without-F and misalignment rules only on values that an accepted write has just stored. For this reason they do not require the reset mask itself to be self-consistent. The stimulus holds the mask constant for the whole run. Inputs change only on falling edges, so every write is one clean strobe. Vectors cover writes that pass and writes that are dropped, with and without the enable, and with both states of the alignment flag.

// File: rtl/isa_ext_pkg.sv
package isa_ext_pkg;
  localparam int EXT_W = 26;

  localparam int BIT_A = 0;
  localparam int BIT_C = 2;
  localparam int BIT_D = 3;
  localparam int BIT_E = 4;
  localparam int BIT_F = 5;
  localparam int BIT_I = 8;
  localparam int BIT_M = 12;
  localparam int BIT_S = 18;
  localparam int BIT_U = 20;

  localparam logic [EXT_W-1:0] KNOWN_EXT =
    (26'd1 << BIT_A) | (26'd1 << BIT_C) | (26'd1 << BIT_D) |
    (26'd1 << BIT_E) | (26'd1 << BIT_F) | (26'd1 << BIT_I) |
    (26'd1 << BIT_M) | (26'd1 << BIT_S) | (26'd1 << BIT_U);

  // A write is eligible only with a base integer set named and no reduced base.
  function automatic logic base_ok(input logic [EXT_W-1:0] data);
    return (data[BIT_I] | data[BIT_E]) & ~data[BIT_E];
  endfunction

  // Masking followed by the two dependency fix-ups.
  function automatic logic [EXT_W-1:0] legal_ext(
    input logic [EXT_W-1:0] data,
    input logic [EXT_W-1:0] supported,
    input logic             aligned
  );
    logic [EXT_W-1:0] v;
    v = data & supported & KNOWN_EXT;
    if (v[BIT_D] && !v[BIT_F]) v[BIT_D] = 1'b0;
    if (v[BIT_C] && !aligned)  v[BIT_C] = 1'b0;
    return v;
  endfunction
endpackage

// File: rtl/isa_wr_filter.sv
module isa_wr_filter
  import isa_ext_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic             wr_en,
  input  logic             writable_en,
  input  logic [EXT_W-1:0] wr_ext,
  input  logic [EXT_W-1:0] hart_ext_mask,
  input  logic             next_pc_aligned,
  input  logic [1:0]       cur_mxl,
  output logic             accept,
  output logic [XLEN-1:0]  legal_val
);
  localparam int PAD_W = XLEN - 2 - EXT_W;

  logic [EXT_W-1:0] ext_clean;

  always_comb begin
    accept    = wr_en & writable_en & base_ok(wr_ext);
    ext_clean = legal_ext(wr_ext, hart_ext_mask, next_pc_aligned);
    legal_val = {cur_mxl, {PAD_W{1'b0}}, ext_clean};
  end
endmodule

// File: rtl/isa_misa_store.sv
module isa_misa_store
  import isa_ext_pkg::*;
#(
  parameter int         XLEN     = 32,
  parameter logic [1:0] MXL_INIT = 2'b01
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic [XLEN-1:0]  legal_val,
  input  logic [EXT_W-1:0] hart_ext_mask,
  output logic [XLEN-1:0]  misa_q,
  output logic             flush_pulse,
  output logic             value_change
);
  localparam int PAD_W = XLEN - 2 - EXT_W;

  assign value_change = accept && (legal_val != misa_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      misa_q      <= {MXL_INIT, {PAD_W{1'b0}}, hart_ext_mask};
      flush_pulse <= 1'b0;
    end else begin
      flush_pulse <= value_change;
      if (accept) misa_q <= legal_val;
    end
  end
endmodule

// File: rtl/isa_ext_legalizer.sv
module isa_ext_legalizer
  import isa_ext_pkg::*;
#(
  parameter int         XLEN     = 32,
  parameter logic [1:0] MXL_INIT = 2'b01
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [XLEN-1:0]  wr_data,
  input  logic [EXT_W-1:0] hart_ext_mask,
  input  logic             writable_en,
  input  logic             next_pc_aligned,
  output logic [XLEN-1:0]  misa_q,
  output logic             flush_pulse
);
  logic            wr_accept;
  logic [XLEN-1:0] wr_legal;
  logic            wr_change;

  isa_wr_filter #(.XLEN(XLEN)) u_filter (
    .wr_en          (wr_en),
    .writable_en    (writable_en),
    .wr_ext         (wr_data[EXT_W-1:0]),
    .hart_ext_mask  (hart_ext_mask),
    .next_pc_aligned(next_pc_aligned),
    .cur_mxl        (misa_q[XLEN-1:XLEN-2]),
    .accept         (wr_accept),
    .legal_val      (wr_legal)
  );

  isa_misa_store #(.XLEN(XLEN), .MXL_INIT(MXL_INIT)) u_store (
    .clk          (clk),
    .rst_n        (rst_n),
    .accept       (wr_accept),
    .legal_val    (wr_legal),
    .hart_ext_mask(hart_ext_mask),
    .misa_q       (misa_q),
    .flush_pulse  (flush_pulse),
    .value_change (wr_change)
  );
endmodule

// File: rtl/isa_ext_legalizer_chk.sv
module isa_ext_legalizer_chk
  import isa_ext_pkg::*;
#(
  parameter int XLEN = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [XLEN-1:0]  wr_data,
  input logic [EXT_W-1:0] hart_ext_mask,
  input logic             writable_en,
  input logic             next_pc_aligned,
  input logic [XLEN-1:0]  misa_q,
  input logic             flush_pulse,
  input logic             wr_accept
);
  // armed: the previous edge was already out of reset, so $past is meaningful.
  logic armed;
  always_ff @(posedge clk) armed <= rst_n;

  assert_ignore_disabled_R2: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(wr_en && !writable_en) |-> $stable(misa_q) && !flush_pulse);

  assert_ignore_no_base_R3: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(wr_en && !wr_data[BIT_I] && !wr_data[BIT_E]) |-> $stable(misa_q));

  assert_ignore_reduced_R4: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(wr_en && wr_data[BIT_E]) |-> $stable(misa_q) && !flush_pulse);

  assert_within_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(wr_accept) |-> (misa_q[EXT_W-1:0] & ~$past(hart_ext_mask)) == '0);

  assert_pad_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(wr_accept && (|wr_data[XLEN-3:EXT_W])) |-> misa_q[XLEN-3:EXT_W] == '0);

  assert_d_needs_f_R6: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(wr_accept) |-> !(misa_q[BIT_D] && !misa_q[BIT_F]));

  assert_c_misalign_R7: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(wr_accept && !next_pc_aligned) |-> !misa_q[BIT_C]);

  assert_mxl_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> $stable(misa_q[XLEN-1:XLEN-2]));

  assert_flush_on_change_R9: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> flush_pulse == (misa_q != $past(misa_q)));

  assert_hold_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(!wr_en) |-> $stable(misa_q) && !flush_pulse);
endmodule

bind isa_ext_legalizer isa_ext_legalizer_chk #(.XLEN(XLEN)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .wr_en          (wr_en),
  .wr_data        (wr_data),
  .hart_ext_mask  (hart_ext_mask),
  .writable_en    (writable_en),
  .next_pc_aligned(next_pc_aligned),
  .misa_q         (misa_q),
  .flush_pulse    (flush_pulse),
  .wr_accept      (wr_accept)
);

// File: tb/isa_ext_legalizer_test.sv
`timescale 1ns/1ps
module isa_ext_legalizer_test;
  localparam logic [25:0] HART = 26'h094112F; // A,B,C,D,F,I,M,S,U,X
  localparam logic [31:0] RST_VAL = 32'h4094112F;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        writable_en = 1'b1;
  logic        next_pc_aligned = 1'b1;
  logic [31:0] misa_q;
  logic        flush_pulse;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  isa_ext_legalizer uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .hart_ext_mask(HART), .writable_en(writable_en),
    .next_pc_aligned(next_pc_aligned), .misa_q(misa_q), .flush_pulse(flush_pulse)
  );

  localparam int NV = 10;
  localparam logic [31:0] V_DATA [NV] = '{
    32'hC0000100, 32'h00001129, 32'h00000108, 32'h0000010C, 32'h0000012C,
    32'h00FFFFFF, 32'h00140000, 32'h0094112F, 32'hFFFFFFEF, 32'hFFFFFFEF};
  localparam bit V_WEN [NV] = '{1,1,1,1,1,1,1,0,1,1};
  localparam bit V_AL  [NV] = '{1,1,1,0,1,1,1,1,1,1};
  string v_tag [NV] = '{"R8","R5","R6","R7","R7","R4","R3","R2","R5","R9"};

  // Independent restatement: bit-by-bit over the letters the block knows.
  function automatic logic [31:0] model(input logic [31:0] cur, input logic [31:0] d,
                                        input bit wen, input bit al);
    logic [31:0] r;
    if (!wen || d[4] || !d[8]) return cur;
    r = {cur[31:30], 30'd0};
    for (int i = 0; i < 26; i++) begin
      case (i)
        0, 2, 3, 4, 5, 8, 12, 18, 20: r[i] = d[i] & HART[i];
        default: r[i] = 1'b0;
      endcase
    end
    if (!r[5]) r[3] = 1'b0;
    if (!al) r[2] = 1'b0;
    return r;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin
    logic [31:0] prev, expv;
    repeat (3) @(negedge clk);
    chk("R1 flush in reset", {31'd0, flush_pulse}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset value", misa_q, RST_VAL);
    chk("R1 flush after reset", {31'd0, flush_pulse}, 32'd0);
    prev = misa_q;

    for (int k = 0; k < NV; k++) begin
      wr_data = V_DATA[k];
      writable_en = V_WEN[k];
      next_pc_aligned = V_AL[k];
      wr_en = 1'b1;
      expv = model(prev, V_DATA[k], V_WEN[k], V_AL[k]);
      @(negedge clk);
      wr_en = 1'b0;
      chk(v_tag[k], misa_q, expv);
      chk({v_tag[k], " R9 pulse"}, {31'd0, flush_pulse}, {31'd0, expv != prev});
      @(negedge clk);
      chk({v_tag[k], " R9 single cycle"}, {31'd0, flush_pulse}, 32'd0);
      chk({v_tag[k], " R10 hold"}, misa_q, expv);
      prev = expv;
    end

    // R10: valid data on the bus without a strobe changes nothing.
    writable_en = 1'b1;
    next_pc_aligned = 1'b1;
    wr_data = 32'h00000100;
    repeat (2) @(negedge clk);
    chk("R10 no strobe", misa_q, prev);
    chk("R10 no strobe flush", {31'd0, flush_pulse}, 32'd0);

    // R2: disabled write of a value that would differ.
    writable_en = 1'b0;
    wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    chk("R2 disabled", misa_q, prev);
    chk("R2 disabled flush", {31'd0, flush_pulse}, 32'd0);
    writable_en = 1'b1;

    // R1: reset mid-run restores the reset value.
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    chk("R1 mid-run reset", misa_q, RST_VAL);
    chk("R1 mid-run flush", {31'd0, flush_pulse}, 32'd0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule